// File: doc/BRIEF.md
# Command-Queue I2C Master

This block is an I2C bus master that software drives through a small word-wide register port. It does not use a per-byte handshake. Software queues command words in a 16-entry transmit queue. A word can open a transfer with a START and an address byte, carry one data byte, or ask for a run of bytes to be received. Any word can also request a STOP once its bytes are done. The engine works through the queue on its own.

Received bytes go into a 16-entry receive queue. Each read of that queue reports an empty flag next to the byte. A status word holds a sticky flag for a finished read and a sticky flag for a refused byte; writing a 1 to a flag clears it. The status word also shows whether the engine is busy. A control word sets the bit-rate divider and the enable, and can flush either queue.

Both bus lines are open-drain. The block only pulls a line low or lets it go, and it reads SDA back to sample acknowledge bits and incoming data.

Top module: `cmdq_i2c_master`

## Requirements
- R1: Register word index 0 (write) queues a command word. Its bits [7:0] are data, bit 8 requests START, bit 9 requests STOP and bit 10 requests a read. A word taken while the engine is idle and not discarding, without bit 8 set, is dropped without bus activity.
- R2: A word with START set produces a START (SDA falls while SCL is high). It then shifts out bits [7:0] MSB first and samples the acknowledge in the ninth bit. A word without START or read shifts out its byte the same way.
- R3: The oversampling tick fires every DIV+1 clocks, where DIV is control bits [7:0]. Each bit takes 16 ticks: SCL is pulled low for 8 ticks and released for 8. SDA changes only while SCL is low, except in START and STOP.
- R4: A word with bit 10 set and no START receives N = bits [7:0] bytes MSB first and queues each one. The master acknowledges (SDA low) every byte but the last, which it leaves unacknowledged.
- R5: Reading word index 2'd1 returns the oldest received byte in bits [7:0] and the empty flag in bit 8 (1 when nothing is queued). A non-empty read removes that byte.
- R6: After the bytes of a STOP-tagged word, the engine drives a STOP (SDA rises while SCL is high). It then leaves both lines released and goes idle.
- R7: Status is read at word index 2. Bit 27 is set when the last byte of a read command completes, bit 21 is set when a byte is not acknowledged, and bit 28 is 1 while the engine is not idle. All status bits are 0 after reset.
- R8: Writing status (index 2) with a 1 in bit 21 or bit 27 clears that flag. Writing all ones clears both.
- R9: On a NAK the engine sets bit 21 and issues a STOP. It then drops queued words up to and including the next STOP-tagged word, unless the refused word itself carried STOP.
- R10: Control (index 3) holds the divider in bits [7:0] and enable in bit 11; both read back and are 0 after reset. While enable is 0, no queued word is taken. Writing 1 to bit 9 or bit 10 flushes the transmit or receive queue; these two bits read back as 0.
- R11: Each queue holds 16 entries. A push into a full queue is dropped, so a 18-byte read leaves exactly the first 16 bytes queued.
- R12: A START word that follows an unfinished transfer produces a repeated START with no STOP in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at index 1) |
| reg_addr | input | 2 | Register word index: 0 command, 1 receive, 2 status, 3 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level seen on the SDA line |

## Verification
The bench attaches a bus-level target model that acknowledges address 0x50, logs written bytes and returns an arithmetic byte sequence. Writes use a sweep of six byte values from 0xFF down to 0x00, which catches bit-order and shift errors. Reads are swept over lengths 1 to 4, which separates a correct acknowledge pattern from one that is off by one at the last byte. The divider sweep measures the SCL period against 16×(DIV+1). A refused address followed by queued words, an 18-byte read, a disabled engine, queue flushes and a repeated START cover discard, overflow, enable and restart ordering.

// File: rtl/cqi2c_pkg.sv
`timescale 1ns/1ps
package cqi2c_pkg;
   localparam int CMD_W    = 11;
   localparam int CB_START = 8;
   localparam int CB_STOP  = 9;
   localparam int CB_READ  = 10;
   localparam int ST_NAK   = 21;
   localparam int ST_DONE  = 27;
   localparam int ST_BUSY  = 28;
   localparam int CT_TXRST = 9;
   localparam int CT_RXRST = 10;
   localparam int CT_EN    = 11;

   typedef enum logic [2:0] {
      E_IDLE, E_FETCH, E_START, E_TXBIT, E_TXACK, E_RXBIT, E_RXACK, E_STOP
   } eng_st_t;
endpackage

// File: rtl/cqi2c_fifo.sv
`timescale 1ns/1ps
module cqi2c_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cqi2c_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [AW:0]      cnt;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign dout    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; cnt <= '0;
      end else if (flush) begin
         wp <= '0; rp <= '0; cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end

   // R11: a full queue stays full when only a push arrives
   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/cqi2c_tick.sv
`timescale 1ns/1ps
module cqi2c_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/cqi2c_engine.sv
`timescale 1ns/1ps
module cqi2c_engine
   import cqi2c_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd,
   output logic             cmd_pop,
   output logic             rx_push,
   output logic [7:0]       rx_byte,
   output logic             nak_set,
   output logic             done_set,
   output logic             busy,
   output logic             scl_pull,
   output logic             sda_pull,
   input  logic             sda_in
);
   eng_st_t    st;
   logic [3:0] ph;
   logic [2:0] bitn;
   logic [7:0] sh, left;
   logic       stop_pend, discard, nak_q, sda_q;
   logic       in_slot;

   assign in_slot  = (st != E_IDLE) && (st != E_FETCH);
   assign cmd_pop  = cmd_valid && en && (st == E_IDLE || st == E_FETCH);
   assign scl_pull = (st == E_FETCH) || (in_slot && !ph[3]);
   assign sda_pull = sda_q;
   assign busy     = (st != E_IDLE);
   assign rx_byte  = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= E_IDLE; ph <= '0; bitn <= '0; sh <= '0; left <= '0;
         stop_pend <= 1'b0; discard <= 1'b0; nak_q <= 1'b0; sda_q <= 1'b0;
         rx_push <= 1'b0; nak_set <= 1'b0; done_set <= 1'b0;
      end else begin
         rx_push <= 1'b0; nak_set <= 1'b0; done_set <= 1'b0;
         case (st)
            E_IDLE: if (cmd_pop) begin
               if (discard) begin
                  if (cmd[CB_STOP]) discard <= 1'b0;
               end else if (cmd[CB_START]) begin
                  sh <= cmd[7:0]; stop_pend <= cmd[CB_STOP]; st <= E_START;
               end
            end
            E_FETCH: if (cmd_pop) begin
               stop_pend <= cmd[CB_STOP]; bitn <= '0;
               sh <= cmd[7:0]; left <= cmd[7:0];
               if (cmd[CB_START])             st <= E_START;
               else if (!cmd[CB_READ])        st <= E_TXBIT;
               else if (cmd[7:0] != 8'd0)     st <= E_RXBIT;
               else if (cmd[CB_STOP])         st <= E_STOP;
            end
            default: if (tick) begin
               ph <= ph + 4'd1;
               case (st)
                  E_START: begin
                     if (ph == 4'd4)  sda_q <= 1'b0;
                     if (ph == 4'd12) sda_q <= 1'b1;
                     if (ph == 4'd15) begin st <= E_TXBIT; bitn <= '0; end
                  end
                  E_TXBIT: begin
                     if (ph == 4'd4) sda_q <= ~sh[7];
                     if (ph == 4'd15) begin
                        sh <= {sh[6:0], 1'b0}; bitn <= bitn + 3'd1;
                        if (bitn == 3'd7) st <= E_TXACK;
                     end
                  end
                  E_TXACK: begin
                     if (ph == 4'd4)  sda_q <= 1'b0;
                     if (ph == 4'd12) nak_q <= sda_in;
                     if (ph == 4'd15) begin
                        if (nak_q) begin
                           nak_set <= 1'b1; discard <= !stop_pend; st <= E_STOP;
                        end else begin
                           st <= stop_pend ? E_STOP : E_FETCH;
                        end
                     end
                  end
                  E_RXBIT: begin
                     if (ph == 4'd4)  sda_q <= 1'b0;
                     if (ph == 4'd12) sh <= {sh[6:0], sda_in};
                     if (ph == 4'd15) begin
                        bitn <= bitn + 3'd1;
                        if (bitn == 3'd7) begin st <= E_RXACK; rx_push <= 1'b1; end
                     end
                  end
                  E_RXACK: begin
                     if (ph == 4'd4) sda_q <= (left != 8'd1);
                     if (ph == 4'd15) begin
                        left <= left - 8'd1;
                        if (left == 8'd1) begin
                           done_set <= 1'b1; st <= stop_pend ? E_STOP : E_FETCH;
                        end else begin
                           st <= E_RXBIT;
                        end
                     end
                  end
                  E_STOP: begin
                     if (ph == 4'd4)  sda_q <= 1'b1;
                     if (ph == 4'd12) sda_q <= 1'b0;
                     if (ph == 4'd15) st <= E_IDLE;
                  end
                  default: ;
               endcase
            end
         endcase
      end
   end

   // R3: with SCL released in two successive cycles, SDA holds outside START/STOP
   a_r3_sda_moves_low_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_pull && !$past(scl_pull) && st != E_START && st != E_STOP)
         |-> (sda_pull == $past(sda_pull)));
   // R6: an idle engine leaves both lines released
   a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_IDLE) |-> (!scl_pull && !sda_pull));
   // R4: in the high half of a receive acknowledge, only the last byte is left unacknowledged
   a_r4_last_byte_nak: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_RXACK && ph >= 4'd8) |-> (sda_pull == (left > 8'd1)));
   // R7: the read-complete pulse follows a receive acknowledge slot
   a_r7_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |-> ($past(st) == E_RXACK));
endmodule

// File: rtl/cmdq_i2c_master.sv
`timescale 1ns/1ps
module cmdq_i2c_master
   import cqi2c_pkg::*;
#(
   parameter int DIV_W      = 8,
   parameter int FIFO_DEPTH = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        scl_pull,
   output logic        sda_pull,
   input  logic        sda_in
);
   localparam int NFLAG = 2;
   localparam int FLAG_POS [NFLAG] = '{ST_NAK, ST_DONE};

   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("cmdq_i2c_master: DIV_W must lie in 1..8");
   end

   logic [DIV_W-1:0] div_q;
   logic             en_q, tick;
   logic             tx_empty, tx_full, tx_pop, tx_flush;
   logic [CMD_W-1:0] tx_dout;
   logic             rx_empty, rx_full, rx_pop, rx_flush, rx_push;
   logic [7:0]       rx_dout, rx_byte;
   logic             nak_set, done_set, busy;
   logic [NFLAG-1:0] flag_q, flag_set;
   logic             wr_cmd, wr_stat, wr_ctl;
   logic             unused_bits;

   assign wr_cmd   = reg_wr && (reg_addr == 2'd0);
   assign wr_stat  = reg_wr && (reg_addr == 2'd2);
   assign wr_ctl   = reg_wr && (reg_addr == 2'd3);
   assign tx_flush = wr_ctl && reg_wdata[CT_TXRST];
   assign rx_flush = wr_ctl && reg_wdata[CT_RXRST];
   assign rx_pop   = reg_rd && (reg_addr == 2'd1) && !rx_empty;
   assign flag_set = {done_set, nak_set};
   assign unused_bits = ^{reg_wdata[31:12], reg_wdata[8], tx_full, rx_full};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0; en_q <= 1'b0;
      end else if (wr_ctl) begin
         div_q <= reg_wdata[DIV_W-1:0]; en_q <= reg_wdata[CT_EN];
      end
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               flag_q[i] <= 1'b0;
         else if (flag_set[i])                     flag_q[i] <= 1'b1;
         else if (wr_stat && reg_wdata[FLAG_POS[i]]) flag_q[i] <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         2'd1: reg_rdata[8:0] = {rx_empty, rx_dout};
         2'd2: begin
            reg_rdata[ST_NAK]  = flag_q[0];
            reg_rdata[ST_DONE] = flag_q[1];
            reg_rdata[ST_BUSY] = busy;
         end
         2'd3: begin
            reg_rdata[DIV_W-1:0] = div_q;
            reg_rdata[CT_EN]     = en_q;
         end
         default: ;
      endcase
   end

   cqi2c_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick));

   cqi2c_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(wr_cmd),
      .din(reg_wdata[CMD_W-1:0]), .pop(tx_pop), .dout(tx_dout),
      .empty(tx_empty), .full(tx_full));

   cqi2c_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push),
      .din(rx_byte), .pop(rx_pop), .dout(rx_dout),
      .empty(rx_empty), .full(rx_full));

   cqi2c_engine u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q),
      .cmd_valid(!tx_empty && !tx_flush), .cmd(tx_dout), .cmd_pop(tx_pop),
      .rx_push(rx_push), .rx_byte(rx_byte), .nak_set(nak_set),
      .done_set(done_set), .busy(busy), .scl_pull(scl_pull),
      .sda_pull(sda_pull), .sda_in(sda_in));

   // R8: a write-one to the refusal flag clears it unless a new refusal arrives
   a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && reg_wdata[ST_NAK] && !nak_set) |=> !flag_q[0]);
endmodule

// File: tb/cmdq_i2c_master_test.sv
`timescale 1ns/1ps
module cmdq_i2c_master_test;
   localparam int START = 256, STOP = 512, READ = 1024;

   logic clk = 1'b0, rst_n;
   logic reg_wr, reg_rd;
   logic [1:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic scl_pull, sda_pull, s_pull;
   wire scl_line = !scl_pull;
   wire sda_line = !(sda_pull || s_pull);

   int checks = 0, fails = 0, cyc = 0;
   int cur_div = 1;

   always #4 clk = ~clk;

   cmdq_i2c_master uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_line));

   // bus-level target model: address 0x50
   logic prev_scl = 1'b1, prev_sda = 1'b1;
   int cnt = 0, wn = 0, rdk = 0, starts = 0, stops = 0, acks = 0, naks = 0;
   int scl_falls = 0, last_rise = 0, last_per = 0;
   bit active = 0, addr_ph = 0, stx = 0, acc = 0, mack = 0, newtx;
   logic [7:0] sr = '0, txb = '0;
   logic [7:0] wlog [64];

   function automatic logic [7:0] rdb(int k);
      return 8'((60 + 29 * k) & 255);
   endfunction
   function automatic logic [7:0] wpat(int k);
      return 8'(255 - 51 * k);
   endfunction

   initial s_pull = 1'b0;
   always @(negedge clk) begin
      cyc++;
      if (scl_line && !prev_scl) begin last_per = cyc - last_rise; last_rise = cyc; end
      if (!scl_line && prev_scl) scl_falls++;
      if (scl_line && prev_scl && prev_sda && !sda_line) begin
         starts++; active = 1; addr_ph = 1; stx = 0; cnt = 0; s_pull <= 1'b0;
      end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
         stops++; active = 0; s_pull <= 1'b0;
      end else if (active && scl_line && !prev_scl) begin
         if (cnt < 8 && !stx) sr = {sr[6:0], sda_line};
         if (cnt == 8 && stx) begin mack = !sda_line; if (mack) acks++; else naks++; end
         cnt++;
      end else if (active && !scl_line && prev_scl) begin
         if (cnt == 8) begin
            if (!stx) begin acc = addr_ph ? (sr[7:1] == 7'h50) : 1'b1; s_pull <= acc; end
            else s_pull <= 1'b0;
         end else if (cnt == 9) begin
            cnt = 0; newtx = 0;
            if (!stx) begin
               if (addr_ph) begin
                  addr_ph = 0;
                  if (!acc) active = 0;
                  else if (sr[0]) begin stx = 1; newtx = 1; end
               end else begin wlog[wn % 64] = sr; wn++; end
            end else if (mack) newtx = 1;
            else begin stx = 0; active = 0; end
            if (newtx) begin txb = rdb(rdk); rdk++; s_pull <= !txb[7]; end
            else s_pull <= 1'b0;
         end else if (stx && cnt >= 1 && cnt <= 7) s_pull <= !txb[7 - cnt];
      end
      prev_scl = scl_line; prev_sda = sda_line;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] v);
      @(negedge clk); reg_addr = a; #1; v = reg_rdata; reg_rd = (a == 2'd1);
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic push(int c);
      wr(2'd0, 32'(c));
   endtask

   task automatic ctl(bit en, int d, int extra);
      cur_div = d;
      wr(2'd3, 32'((en ? 2048 : 0) | extra | d));
   endtask

   task automatic settle();
      int q = 0;
      while (q < 200) begin
         @(negedge clk); reg_addr = 2'd2; #1;
         if (reg_rdata[28]) q = 0; else q++;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #1_400_000;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      int w0, s0, p0, k0, f0;
      rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      rd(2'd2, v); chk("R7 status after reset", v, 0);
      rd(2'd1, v); chk("R5 rx empty after reset", 32'(v[8]), 1);
      rd(2'd3, v); chk("R10 control after reset", v, 0);
      chk("R6 lines released after reset", {30'd0, scl_pull, sda_pull}, 0);

      ctl(1, 1, 0);
      rd(2'd3, v); chk("R10 control readback", v, 32'h801);

      // R1 R2 R6: write sweep over six byte values
      w0 = wn; s0 = starts; p0 = stops;
      push(START | 8'hA0);
      for (int i = 0; i < 6; i++) push(wpat(i) | (i == 5 ? STOP : 0));
      settle();
      chk("R1 bytes delivered", 32'(wn - w0), 6);
      for (int i = 0; i < 6; i++) chk("R2 written byte", {24'd0, wlog[(w0 + i) % 64]}, {24'd0, wpat(i)});
      chk("R2 one start", 32'(starts - s0), 1);
      chk("R6 one stop", 32'(stops - p0), 1);
      chk("R6 released after stop", {30'd0, scl_pull, sda_pull}, 0);
      rd(2'd2, v); chk("R7 no nak on accepted write", 32'(v[21]), 0);

      // R3: divider sweep, period of the last two bit slots
      for (int d = 0; d < 4; d++) begin
         ctl(1, d * 2, 0);
         w0 = wn;
         push(START | 8'hA0); push(8'h11 | STOP);
         settle();
         chk("R3 scl period", 32'(last_per), 32'(16 * (d * 2 + 1)));
         chk("R2 byte under divider", {24'd0, wlog[w0 % 64]}, 32'h11);
      end
      ctl(1, 1, 0);

      // R4 R5 R7 R8: read lengths 1..4
      for (int n = 1; n <= 4; n++) begin
         k0 = rdk; acks = 0; naks = 0;
         push(START | 8'hA1); push(READ | STOP | n);
         settle();
         chk("R4 master acks", 32'(acks), 32'(n - 1));
         chk("R4 final nak", 32'(naks), 1);
         for (int i = 0; i < n; i++) begin
            rd(2'd1, v);
            chk("R5 rx byte", v & 32'h1FF, {24'd0, rdb(k0 + i)});
         end
         rd(2'd1, v); chk("R5 empty after drain", 32'(v[8]), 1);
         rd(2'd2, v); chk("R7 read done flag", 32'(v[27]), 1);
         wr(2'd2, 32'h0800_0000);
         rd(2'd2, v); chk("R8 done cleared", 32'(v[27]), 0);
      end

      // R9: refused address, discard up to the stop-tagged word
      w0 = wn; p0 = stops;
      push(START | 8'h66); push(8'h01); push(8'h02 | STOP);
      push(START | 8'hA0); push(8'h77 | STOP);
      settle();
      rd(2'd2, v); chk("R7 nak flag set", 32'(v[21]), 1);
      chk("R9 only later transfer delivered", 32'(wn - w0), 1);
      chk("R9 delivered byte", {24'd0, wlog[w0 % 64]}, 32'h77);
      chk("R9 two stops", 32'(stops - p0), 2);
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd2, v); chk("R8 all-ones clears", v, 0);

      // R12: repeated start
      w0 = wn; s0 = starts; p0 = stops; k0 = rdk;
      push(START | 8'hA0); push(8'h42); push(START | 8'hA1); push(READ | STOP | 2);
      settle();
      chk("R12 two starts", 32'(starts - s0), 2);
      chk("R12 one stop", 32'(stops - p0), 1);
      chk("R12 written byte", {24'd0, wlog[w0 % 64]}, 32'h42);
      for (int i = 0; i < 2; i++) begin
         rd(2'd1, v); chk("R12 read byte", v & 32'h1FF, {24'd0, rdb(k0 + i)});
      end

      // R11: 18-byte read keeps the first 16
      k0 = rdk;
      push(START | 8'hA1); push(READ | STOP | 18);
      settle();
      for (int i = 0; i < 16; i++) begin
         rd(2'd1, v); chk("R11 kept byte", v & 32'h1FF, {24'd0, rdb(k0 + i)});
      end
      rd(2'd1, v); chk("R11 nothing past depth", 32'(v[8]), 1);

      // R10: enable gates fetch, flushes
      f0 = scl_falls; w0 = wn;
      ctl(0, 1, 0);
      push(START | 8'hA0); push(8'h99 | STOP);
      repeat (400) @(negedge clk);
      rd(2'd2, v); chk("R10 idle while disabled", 32'(v[28]), 0);
      chk("R10 no bus activity while disabled", 32'(scl_falls - f0), 0);
      ctl(0, 1, 512);
      rd(2'd3, v); chk("R10 flush bits read zero", v, 1);
      ctl(1, 1, 0);
      settle();
      chk("R10 tx flush dropped words", 32'(wn - w0), 0);
      push(START | 8'hA0); push(8'h99 | STOP);
      settle();
      chk("R10 enabled word delivered", {24'd0, wlog[w0 % 64]}, 32'h99);
      push(START | 8'hA1); push(READ | STOP | 2);
      settle();
      ctl(1, 1, 1024);
      rd(2'd1, v); chk("R10 rx flush empties", 32'(v[8]), 1);

      // R1: a word without START from idle is dropped
      f0 = scl_falls; w0 = wn;
      push(8'h55);
      settle();
      chk("R1 no activity for bare word", 32'(scl_falls - f0), 0);
      chk("R1 bare word not delivered", 32'(wn - w0), 0);

      summary();
      $finish;
   end
endmodule